// File: doc/BRIEF.md
# Three-Port I/O Block With Latched Address Output

This block sits between an 8-bit microcontroller bus and three 8-bit pin groups, named E, F and G. Each pin group is split into two 4-bit halves. A half either carries general-purpose I/O or drives a 4-bit slice of a bus address captured by the address strobe. The attached bus type selects which address slice, if any, goes to each half. The microcontroller writes three run-time registers per group: data-out, direction and control. It also drives a global output-enable input. Together these decide which pins actually drive.

Group F has a second use as a data bus port for buses that do not multiplex address and data. In that use it passes the data bus and its general I/O function is off. Each pin appears on the ports as an output value plus a per-bit drive-enable. Every pin is also sampled into an input register on each clock.

Pin bit layout is the same on every pin vector. Group E is bits 7:0, group F is bits 15:8 and group G is bits 23:16. In each group the low half is bits 3:0 and the high half is bits 7:4.

Top module: `latched_addr_port`

## Requirements
- R1: The 16-bit address register loads `ad_in` on every clock edge where `ale` is high. It holds its value on every edge where `ale` is low. Reset clears it to 0.
- R2: After reset, with `oe` low, no pin drives (`pin_oe` = 0). All data-out, direction and control bits are 0.
- R3: A half that carries address drives the latched address slice on `pin_out`. Each of its bits drives when `oe` is 1, or when both that bit's direction bit and control bit are 1.
- R4: With `bus_mode` = 0 (8-bit multiplexed), the low half of E, F and G carries address bits 3:0, and the high half of each carries bits 7:4.
- R5: With `bus_mode` = 1 (8-bit non-multiplexed), only G carries address: bits 3:0 on its low half and bits 7:4 on its high half. All E and F halves are general I/O.
- R6: With `bus_mode` = 2 (paged wide address), only G carries address: bits 11:8 on its low half and bits 15:12 on its high half.
- R7: With `bus_mode` = 3 (extended address), the high halves of E and F carry bits 7:4 and the low half of G carries bits 11:8. The other three halves are general I/O.
- R8: A half with no address function outputs its data-out bits. It drives exactly where its direction bits are 1. Both `oe` and the control bits have no effect on it.
- R9: With `f_data_mode` = 1, group F outputs `db_wdata` and all eight F bits drive exactly when `db_drive` is 1. This holds whatever the bus mode and registers are. `db_rdata` always equals the F pin inputs.
- R10: `port_in_q` equals the value of `pin_in` at the previous clock edge.
- R11: When `wr_en` = 1, a write goes to group `wr_port` (0=E, 1=F, 2=G) and register `wr_kind` (0=data-out, 1=direction, 2=control). The new value is `wr_data`. A `wr_port` or `wr_kind` of 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_mode | input | 2 | Attached bus type, encoded as in R4 to R7 |
| ale | input | 1 | Address strobe; address loads while high |
| ad_in | input | 16 | Address from the bus |
| oe | input | 1 | Global output enable for address halves |
| f_data_mode | input | 1 | Group F works as a data bus port |
| db_wdata | input | 8 | Data driven onto group F in data port use |
| db_drive | input | 1 | Drive group F with `db_wdata` in data port use |
| db_rdata | output | 8 | Group F pin inputs returned to the bus |
| wr_en | input | 1 | Register write strobe |
| wr_port | input | 2 | Write target group |
| wr_kind | input | 2 | Write target register |
| wr_data | input | 8 | Write data |
| pin_in | input | 24 | Pin input values |
| pin_out | output | 24 | Pin output values |
| pin_oe | output | 24 | Per-pin drive enables |
| port_in_q | output | 24 | Pin inputs registered each clock |

## Verification
The assertions assume that `bus_mode`, `oe`, `f_data_mode` and the data port inputs are stable across each clock edge and never X after reset. The stimulus meets this by changing every input only on the falling clock edge, to defined values. The address properties also assume `ale` is an ordinary level input sampled on the clock. Strobe pulses in the stimulus therefore last at least one full clock, and `ad_in` keeps changing while the strobe is low, so that the hold behaviour can be observed.

// File: rtl/lap_pkg.sv
package lap_pkg;
  localparam int NIB_W        = 4;
  localparam int PORT_W       = 8;
  localparam int NUM_PORTS    = 3;
  localparam int NIB_PER_PORT = PORT_W / NIB_W;
  localparam int NUM_NIB      = NUM_PORTS * NIB_PER_PORT;
  localparam int PIN_W        = NUM_PORTS * PORT_W;
  localparam int ADDR_W       = 16;
  localparam int SEL_W        = $clog2(ADDR_W / NIB_W);

  typedef enum logic [1:0] {
    BUS_MUX8    = 2'd0,
    BUS_NONMUX8 = 2'd1,
    BUS_PAGED   = 2'd2,
    BUS_EXT     = 2'd3
  } bus_mode_e;

  typedef enum logic [1:0] {
    REG_DOUT = 2'd0,
    REG_DIR  = 2'd1,
    REG_CTRL = 2'd2,
    REG_NONE = 2'd3
  } reg_kind_e;

  typedef struct packed {
    logic             valid;
    logic [SEL_W-1:0] sel;
  } nib_route_t;

  // nib: 0=E lo, 1=E hi, 2=F lo, 3=F hi, 4=G lo, 5=G hi
  function automatic nib_route_t route_nibble(bus_mode_e mode, int unsigned nib);
    nib_route_t r;
    r.valid = 1'b0;
    r.sel   = '0;
    unique case (mode)
      BUS_MUX8: begin
        r.valid = 1'b1;
        r.sel   = SEL_W'(nib % NIB_PER_PORT);
      end
      BUS_NONMUX8: begin
        r.valid = (nib >= 4);
        r.sel   = SEL_W'(nib - 4);
      end
      BUS_PAGED: begin
        r.valid = (nib >= 4);
        r.sel   = SEL_W'(nib - 2);
      end
      BUS_EXT: begin
        r.valid = (nib == 1) || (nib == 3) || (nib == 4);
        r.sel   = (nib == 4) ? SEL_W'(2) : SEL_W'(1);
      end
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/lap_addr_latch.sv
module lap_addr_latch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ale,
  input  logic [W-1:0] ad_in,
  output logic [W-1:0] addr_q
);
  logic [W-1:0] addr_d;

  always_comb begin
    addr_d = addr_q;
    if (ale) addr_d = ad_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end
endmodule

// File: rtl/lap_reg_file.sv
module lap_reg_file
  import lap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_port,
  input  logic [1:0]        wr_kind,
  input  logic [PORT_W-1:0] wr_data,
  output logic [PIN_W-1:0]  dout_q,
  output logic [PIN_W-1:0]  dir_q,
  output logic [PIN_W-1:0]  ctrl_q
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic              hit;
    logic [PORT_W-1:0] dout_d, dir_d, ctrl_d;

    assign hit = wr_en && (wr_port == 2'(p));

    always_comb begin
      dout_d = dout_q[p*PORT_W +: PORT_W];
      dir_d  = dir_q [p*PORT_W +: PORT_W];
      ctrl_d = ctrl_q[p*PORT_W +: PORT_W];
      if (hit) begin
        unique case (reg_kind_e'(wr_kind))
          REG_DOUT: dout_d = wr_data;
          REG_DIR:  dir_d  = wr_data;
          REG_CTRL: ctrl_d = wr_data;
          default:  ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dout_q[p*PORT_W +: PORT_W] <= '0;
        dir_q [p*PORT_W +: PORT_W] <= '0;
        ctrl_q[p*PORT_W +: PORT_W] <= '0;
      end else begin
        dout_q[p*PORT_W +: PORT_W] <= dout_d;
        dir_q [p*PORT_W +: PORT_W] <= dir_d;
        ctrl_q[p*PORT_W +: PORT_W] <= ctrl_d;
      end
    end
  end
endmodule

// File: rtl/lap_nibble_drv.sv
module lap_nibble_drv
  import lap_pkg::*;
(
  input  nib_route_t        route,
  input  logic [ADDR_W-1:0] addr,
  input  logic              oe,
  input  logic [NIB_W-1:0]  dout,
  input  logic [NIB_W-1:0]  dir,
  input  logic [NIB_W-1:0]  ctrl,
  output logic [NIB_W-1:0]  val,
  output logic [NIB_W-1:0]  drv
);
  logic [NIB_W-1:0] addr_nib;

  always_comb begin
    addr_nib = addr[{route.sel, 2'b00} +: NIB_W];
    if (route.valid) begin
      val = addr_nib;
      drv = {NIB_W{oe}} | (dir & ctrl);
    end else begin
      val = dout;
      drv = dir;
    end
  end
endmodule

// File: rtl/latched_addr_port.sv
module latched_addr_port
  import lap_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              bus_mode,
  input  logic                    ale,
  input  logic [lap_pkg::ADDR_W-1:0] ad_in,
  input  logic                    oe,
  input  logic                    f_data_mode,
  input  logic [lap_pkg::PORT_W-1:0] db_wdata,
  input  logic                    db_drive,
  output logic [lap_pkg::PORT_W-1:0] db_rdata,
  input  logic                    wr_en,
  input  logic [1:0]              wr_port,
  input  logic [1:0]              wr_kind,
  input  logic [lap_pkg::PORT_W-1:0] wr_data,
  input  logic [lap_pkg::PIN_W-1:0]  pin_in,
  output logic [lap_pkg::PIN_W-1:0]  pin_out,
  output logic [lap_pkg::PIN_W-1:0]  pin_oe,
  output logic [lap_pkg::PIN_W-1:0]  port_in_q
);
  localparam int F_LSB = PORT_W;

  logic [ADDR_W-1:0] addr_q;
  logic [PIN_W-1:0]  dout_q, dir_q, ctrl_q;
  logic [PIN_W-1:0]  nib_val, nib_drv;
  logic [PIN_W-1:0]  port_in_d;

  lap_addr_latch #(.W(ADDR_W)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .ale    (ale),
    .ad_in  (ad_in),
    .addr_q (addr_q)
  );

  lap_reg_file u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_port (wr_port),
    .wr_kind (wr_kind),
    .wr_data (wr_data),
    .dout_q  (dout_q),
    .dir_q   (dir_q),
    .ctrl_q  (ctrl_q)
  );

  for (genvar n = 0; n < NUM_NIB; n++) begin : g_nib
    nib_route_t route;
    assign route = route_nibble(bus_mode_e'(bus_mode), n);

    lap_nibble_drv u_drv (
      .route (route),
      .addr  (addr_q),
      .oe    (oe),
      .dout  (dout_q[n*NIB_W +: NIB_W]),
      .dir   (dir_q [n*NIB_W +: NIB_W]),
      .ctrl  (ctrl_q[n*NIB_W +: NIB_W]),
      .val   (nib_val[n*NIB_W +: NIB_W]),
      .drv   (nib_drv[n*NIB_W +: NIB_W])
    );
  end

  // group F data port use overrides both general I/O and address output
  always_comb begin
    pin_out = nib_val;
    pin_oe  = nib_drv;
    if (f_data_mode) begin
      pin_out[F_LSB +: PORT_W] = db_wdata;
      pin_oe [F_LSB +: PORT_W] = {PORT_W{db_drive}};
    end
  end

  assign db_rdata  = pin_in[F_LSB +: PORT_W];
  assign port_in_d = pin_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) port_in_q <= '0;
    else        port_in_q <= port_in_d;
  end
endmodule

// File: rtl/lap_checker.sv
module lap_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  bus_mode,
  input logic        ale,
  input logic [15:0] ad_in,
  input logic        oe,
  input logic        f_data_mode,
  input logic [7:0]  db_wdata,
  input logic        db_drive,
  input logic [23:0] pin_in,
  input logic [23:0] pin_out,
  input logic [23:0] pin_oe,
  input logic [23:0] port_in_q,
  input logic [15:0] addr_q,
  input logic [23:0] dir_q,
  input logic [23:0] ctrl_q
);
  AST_LATCH_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> addr_q == $past(ad_in)); // R1

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ale |=> $stable(addr_q)); // R1

  AST_ADDR_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_mode == 2'd0 && !oe) |-> pin_oe[7:0] == (dir_q[7:0] & ctrl_q[7:0])); // R3

  AST_PAGED_G: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_mode == 2'd2 && oe) |-> (pin_oe[23:16] == 8'hFF && pin_out[23:16] == addr_q[15:8])); // R6

  AST_NONMUX_GPIO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_mode == 2'd1 && !f_data_mode) |-> pin_oe[15:0] == dir_q[15:0]); // R8

  AST_DATA_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    f_data_mode |-> (pin_oe[15:8] == {8{db_drive}} && pin_out[15:8] == db_wdata)); // R9

  AST_IN_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> port_in_q == $past(pin_in)); // R10
endmodule

bind latched_addr_port lap_checker chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_mode    (bus_mode),
  .ale         (ale),
  .ad_in       (ad_in),
  .oe          (oe),
  .f_data_mode (f_data_mode),
  .db_wdata    (db_wdata),
  .db_drive    (db_drive),
  .pin_in      (pin_in),
  .pin_out     (pin_out),
  .pin_oe      (pin_oe),
  .port_in_q   (port_in_q),
  .addr_q      (addr_q),
  .dir_q       (dir_q),
  .ctrl_q      (ctrl_q)
);

// File: tb/latched_addr_port_tb_top.sv
`timescale 1ns/1ps
module latched_addr_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  bus_mode;
  logic        ale;
  logic [15:0] ad_in;
  logic        oe;
  logic        f_data_mode;
  logic [7:0]  db_wdata;
  logic        db_drive;
  logic [7:0]  db_rdata;
  logic        wr_en;
  logic [1:0]  wr_port;
  logic [1:0]  wr_kind;
  logic [7:0]  wr_data;
  logic [23:0] pin_in;
  logic [23:0] pin_out;
  logic [23:0] pin_oe;
  logic [23:0] port_in_q;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [15:0] m_addr;
  logic [23:0] m_dout, m_dir, m_ctrl;

  always #2.5 clk = ~clk;

  latched_addr_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .ale(ale), .ad_in(ad_in),
    .oe(oe), .f_data_mode(f_data_mode), .db_wdata(db_wdata), .db_drive(db_drive),
    .db_rdata(db_rdata), .wr_en(wr_en), .wr_port(wr_port), .wr_kind(wr_kind),
    .wr_data(wr_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .port_in_q(port_in_q)
  );

  // address slice index for a half, -1 when the half is general I/O
  function automatic int slice_of(logic [1:0] mode, int nib);
    case (mode)
      2'd0: return nib % 2;                          // R4
      2'd1: return (nib == 4) ? 0 : (nib == 5) ? 1 : -1; // R5
      2'd2: return (nib == 4) ? 2 : (nib == 5) ? 3 : -1; // R6
      default: return (nib == 1 || nib == 3) ? 1 : (nib == 4) ? 2 : -1; // R7
    endcase
  endfunction

  function automatic logic [47:0] expect_pins();
    logic [23:0] v, d;
    for (int n = 0; n < 6; n++) begin
      int s;
      s = slice_of(bus_mode, n);
      if (s >= 0) begin
        v[n*4 +: 4] = m_addr[s*4 +: 4];
        d[n*4 +: 4] = {4{oe}} | (m_dir[n*4 +: 4] & m_ctrl[n*4 +: 4]);
      end else begin
        v[n*4 +: 4] = m_dout[n*4 +: 4];
        d[n*4 +: 4] = m_dir[n*4 +: 4];
      end
    end
    if (f_data_mode) begin
      v[15:8] = db_wdata;
      d[15:8] = {8{db_drive}};
    end
    return {v, d};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // model update for the inputs that were present at the last rising edge
  task automatic model_step();
    if (ale) m_addr = ad_in;
    if (wr_en && wr_port != 2'd3) begin
      case (wr_kind)
        2'd0: m_dout[wr_port*8 +: 8] = wr_data;
        2'd1: m_dir [wr_port*8 +: 8] = wr_data;
        2'd2: m_ctrl[wr_port*8 +: 8] = wr_data;
        default: ;
      endcase
    end
  endtask

  task automatic cycle(string req);
    logic [23:0] pin_snap;
    pin_snap = pin_in;
    @(posedge clk);
    @(negedge clk);
    model_step();
    check(req, {16'h0, pin_out, pin_oe}, {16'h0, expect_pins()});
    check("R10", {40'h0, port_in_q}, {40'h0, pin_snap});
    if (f_data_mode) check("R9", {56'h0, db_rdata}, {56'h0, pin_in[15:8]});
  endtask

  task automatic idle_inputs();
    wr_en = 0; wr_port = 0; wr_kind = 0; wr_data = 0; ale = 0;
  endtask

  task automatic write_reg(logic [1:0] p, logic [1:0] k, logic [7:0] d, string req);
    wr_en = 1; wr_port = p; wr_kind = k; wr_data = d;
    cycle(req);
    wr_en = 0;
  endtask

  function automatic string mode_req(logic [1:0] m);
    case (m)
      2'd0: return "R4";
      2'd1: return "R5";
      2'd2: return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    rst_n = 0; bus_mode = 0; ad_in = 0; oe = 0; f_data_mode = 0;
    db_wdata = 0; db_drive = 0; pin_in = 0;
    idle_inputs();
    m_addr = 0; m_dout = 0; m_dir = 0; m_ctrl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2: reset state at the ports
    check("R2", {40'h0, pin_oe}, 64'h0);
    check("R2", {40'h0, pin_out}, 64'h0);
    cycle("R2");

    // R1: capture then hold while the bus keeps changing
    ale = 1; ad_in = 16'hA5C3; cycle("R1");
    ale = 0; ad_in = 16'h0F0F; oe = 1; cycle("R1");
    check("R1", {40'h0, pin_out}, {40'h0, 8'hC3, 8'hC3, 8'hC3});

    // R11: writes, including ignored targets
    write_reg(2'd2, 2'd1, 8'hF0, "R11");
    write_reg(2'd2, 2'd2, 8'h3C, "R11");
    write_reg(2'd3, 2'd1, 8'hFF, "R11");
    write_reg(2'd0, 2'd3, 8'hFF, "R11");
    oe = 0; cycle("R3");
    check("R3", {40'h0, pin_oe}, {40'h0, 8'h30, 16'h0});

    // R8: non-address halves ignore oe and control
    bus_mode = 2'd1;
    write_reg(2'd0, 2'd0, 8'h96, "R8");
    write_reg(2'd0, 2'd1, 8'h0F, "R8");
    write_reg(2'd0, 2'd2, 8'hF0, "R8");
    oe = 1; cycle("R8");
    check("R8", {48'h0, pin_out[7:0], pin_oe[7:0]}, {48'h0, 8'h96, 8'h0F});

    // R6: paged mode high address on G
    bus_mode = 2'd2; ale = 1; ad_in = 16'h7E21; cycle("R6");
    ale = 0; cycle("R6");
    check("R6", {48'h0, pin_out[23:16], pin_oe[23:16]}, {48'h0, 8'h7E, 8'hFF});

    // R7 and R9: extended mode, then data port on F
    bus_mode = 2'd3; oe = 0; cycle("R7");
    f_data_mode = 1; db_wdata = 8'h5A; db_drive = 1; pin_in = 24'h00C700; cycle("R9");
    check("R9", {48'h0, pin_out[15:8], pin_oe[15:8]}, {48'h0, 8'h5A, 8'hFF});
    db_drive = 0; cycle("R9");
    f_data_mode = 0;

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      bus_mode    = 2'($urandom_range(0, 3));
      ale         = ($urandom_range(0, 3) == 0);
      ad_in       = 16'($urandom);
      oe          = ($urandom_range(0, 3) == 0);
      f_data_mode = ($urandom_range(0, 4) == 0);
      db_wdata    = 8'($urandom);
      db_drive    = 1'($urandom);
      pin_in      = 24'($urandom);
      wr_en       = ($urandom_range(0, 2) == 0);
      wr_port     = 2'($urandom);
      wr_kind     = 2'($urandom);
      wr_data     = 8'($urandom);
      cycle(f_data_mode ? "R9" : mode_req(bus_mode));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule